// File: doc/BRIEF.md
# Block Transfer Engine with Bus Handshake

This block copies a run of words from a source region to a destination region, or from a peripheral data register to memory, so that the CPU does not handle each word. Software fills four configuration registers through a simple write port: a source address, a destination address, a word count with a per-burst size, and a control word. The control word picks, for each side separately, whether the address stays fixed or steps by one per word, and whether a trigger starts the whole job or only one burst.

Once armed, the engine waits for a trigger pulse from a peripheral. It then raises a bus request and waits for the CPU's acknowledge. While it holds the bus, it issues read and write cycles with a variable-delay ready handshake. After at most one burst of words it drops the request and waits for the acknowledge to fall before it counts the bus as returned. A sticky completion flag and a one-cycle interrupt pulse report the end of the job. A software abort finishes the word in flight, returns the bus, and raises a separate aborted flag.

Top module: `dma_ctrl`

## Requirements
- R1: Register writes use `cfg_addr_i`: 0 = source address, 1 = destination address, 2 = word count in bits [15:0] and burst size in bits [23:16], 3 = control. Control bits: 0 start, 1 source steps, 2 destination steps, 3 per-burst trigger mode, 4 abort. A start write with a non-zero count arms the engine.
- R2: An armed engine raises no bus request until `trig_i` is sampled high.
- R3: `bus_stb_o` is asserted only while both `bus_req_o` and `bus_ack_i` are high.
- R4: Each bus ownership period moves at most the burst size in words. A burst size of 0 means the whole job runs in one period. Between periods `bus_req_o` falls, and it is not raised again while `bus_ack_i` is still high.
- R5: Each side's address is either fixed or incremented by one after every word, chosen independently by control bits 1 and 2.
- R6: In per-burst trigger mode each burst needs its own trigger. Otherwise one trigger runs every burst of the job.
- R7: Each bus cycle holds its address, write enable and write data stable until `bus_rdy_i`. Read data is taken in the cycle `bus_rdy_i` is high.
- R8: When the count reaches zero and the bus has been returned, `done_o` is set and `irq_o` pulses for one cycle. A start with a count of 0 sets `done_o` at once and uses no bus cycle.
- R9: While a job is active, writes to every register are ignored, except the abort bit of the control word.
- R10: An abort completes the word in flight, returns the bus, sets `aborted_o`, leaves `done_o` low and pulses `irq_o`. `done_o` and `aborted_o` are never high together.
- R11: After reset, all bus outputs, `done_o`, `aborted_o` and `irq_o` are low. A new start clears both status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| trig_i | input | 1 | Peripheral trigger |
| bus_req_o | output | 1 | Bus request to CPU |
| bus_ack_i | input | 1 | Bus acknowledge from CPU |
| bus_stb_o | output | 1 | Memory cycle strobe |
| bus_we_o | output | 1 | Memory write enable |
| bus_addr_o | output | 16 | Memory address |
| bus_wdata_o | output | 16 | Memory write data |
| bus_rdata_i | input | 16 | Memory read data |
| bus_rdy_i | input | 1 | Memory cycle complete |
| done_o | output | 1 | Job finished (sticky) |
| aborted_o | output | 1 | Job aborted (sticky) |
| irq_o | output | 1 | One-cycle end-of-job pulse |

## Verification
The copy path is tried with both sides stepping and a burst size smaller than the count. This separates correct burst splitting from a single long ownership, because the number of request rises is checked. A fixed source and a fixed destination each show that only the chosen side stops stepping: the first repeats one value, the second keeps only the last word. Per-burst trigger mode is compared with a run that has the same count, which separates one trigger per job from one per burst. Writes during a job, an abort in mid-job and a zero count check that busy writes are ignored, that aborted and done differ, and that a zero count takes the shortcut that skips the bus.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_REQ, ST_READ, ST_WRITE, ST_REL
  } dma_state_e;

  localparam logic [1:0] REG_SRC = 2'd0;
  localparam logic [1:0] REG_DST = 2'd1;
  localparam logic [1:0] REG_LEN = 2'd2;
  localparam logic [1:0] REG_CTL = 2'd3;

  localparam int unsigned CTL_START   = 0;
  localparam int unsigned CTL_SRC_INC = 1;
  localparam int unsigned CTL_DST_INC = 2;
  localparam int unsigned CTL_RPT     = 3;
  localparam int unsigned CTL_ABORT   = 4;
endpackage

// File: rtl/dma_cfg.sv
module dma_cfg
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16,
  parameter int unsigned BW = 8,
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          busy_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [LW-1:0] len_o,
  output logic [BW-1:0] blk_o,
  output logic          src_inc_o,
  output logic          dst_inc_o,
  output logic          rpt_o,
  output logic          start_o,
  output logic          abort_o
);
  logic wr_ok;
  assign wr_ok = we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o     <= '0;
      dst_o     <= '0;
      len_o     <= '0;
      blk_o     <= '0;
      src_inc_o <= 1'b0;
      dst_inc_o <= 1'b0;
      rpt_o     <= 1'b0;
    end else if (wr_ok) begin
      case (addr_i)
        REG_SRC: src_o <= wdata_i[AW-1:0];
        REG_DST: dst_o <= wdata_i[AW-1:0];
        REG_LEN: begin
          len_o <= wdata_i[LW-1:0];
          blk_o <= wdata_i[LW+BW-1:LW];
        end
        default: begin
          src_inc_o <= wdata_i[CTL_SRC_INC];
          dst_inc_o <= wdata_i[CTL_DST_INC];
          rpt_o     <= wdata_i[CTL_RPT];
        end
      endcase
    end
  end

  assign start_o = wr_ok && (addr_i == REG_CTL) && wdata_i[CTL_START];
  assign abort_o = we_i && busy_i && (addr_i == REG_CTL) && wdata_i[CTL_ABORT];

  // R9: configuration is frozen during a job
  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && we_i) |=> ($stable(len_o) && $stable(blk_o) && $stable(src_o)
                          && $stable(dst_o) && $stable(rpt_o)));
endmodule

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               addr_o <= '0;
    else if (load_i)           addr_o <= base_i;
    else if (step_i && inc_i)  addr_o <= addr_o + AW'(1);
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 16,
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [LW-1:0] len_i,
  input  logic [BW-1:0] blk_i,
  input  logic          rpt_i,
  input  logic          trig_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic          bus_ack_i,
  input  logic          bus_rdy_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          busy_o,
  output logic          step_o,
  output logic          bus_req_o,
  output logic          bus_stb_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          done_o,
  output logic          aborted_o,
  output logic          irq_o
);
  dma_state_e    state_q;
  logic [LW-1:0] remain_q;
  logic [BW-1:0] burst_q;
  logic [DW-1:0] buf_q;
  logic          abort_pend_q;
  logic          word_done, burst_end, stop_req;

  assign word_done = (state_q == ST_WRITE) && bus_rdy_i;
  assign burst_end = (blk_i != '0) && (burst_q == BW'(1));
  assign stop_req  = abort_pend_q || abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      remain_q     <= '0;
      burst_q      <= '0;
      buf_q        <= '0;
      abort_pend_q <= 1'b0;
      done_o       <= 1'b0;
      aborted_o    <= 1'b0;
      irq_o        <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (abort_i && state_q != ST_IDLE) abort_pend_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (start_i) begin
          done_o       <= 1'b0;
          aborted_o    <= 1'b0;
          abort_pend_q <= 1'b0;
          remain_q     <= len_i;
          if (len_i == '0) begin
            done_o <= 1'b1;
            irq_o  <= 1'b1;
          end else begin
            state_q <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (abort_i) begin
            aborted_o <= 1'b1;
            irq_o     <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (trig_i) begin
            burst_q <= blk_i;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (abort_i)        state_q <= ST_REL;
          else if (bus_ack_i) state_q <= ST_READ;
        end
        ST_READ: if (bus_rdy_i) begin
          buf_q   <= bus_rdata_i;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (word_done) begin
          remain_q <= remain_q - LW'(1);
          burst_q  <= burst_q - BW'(1);
          if (remain_q == LW'(1) || burst_end || stop_req) state_q <= ST_REL;
          else                                              state_q <= ST_READ;
        end
        ST_REL: if (!bus_ack_i) begin
          if (remain_q == '0) begin
            done_o  <= 1'b1;
            irq_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (stop_req) begin
            aborted_o <= 1'b1;
            irq_o     <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (rpt_i) begin
            state_q <= ST_ARMED;
          end else begin
            burst_q <= blk_i;
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign step_o      = word_done;
  assign bus_req_o   = (state_q == ST_REQ) || (state_q == ST_READ) || (state_q == ST_WRITE);
  assign bus_stb_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign bus_we_o    = (state_q == ST_WRITE);
  assign bus_addr_o  = (state_q == ST_WRITE) ? dst_addr_i : src_addr_i;
  assign bus_wdata_o = buf_q;

  // R4: a new request never overlaps the previous acknowledge
  p_req_after_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> !bus_ack_i);
  // R8: completion is only reported with the bus returned
  p_done_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !bus_req_o);
  // R10: the two end flags exclude each other
  p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && aborted_o));
  // R10: an end pulse always comes with a status flag
  p_irq_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done_o || aborted_o));
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 16,
  parameter int unsigned BW = 8,
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [CW-1:0] cfg_wdata_i,
  input  logic          trig_i,
  output logic          bus_req_o,
  input  logic          bus_ack_i,
  output logic          bus_stb_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_rdy_i,
  output logic          done_o,
  output logic          aborted_o,
  output logic          irq_o
);
  localparam int unsigned NPTR = 2;

  logic [AW-1:0] src_base, dst_base;
  logic [LW-1:0] len;
  logic [BW-1:0] blk;
  logic          src_inc, dst_inc, rpt, start, abort_req, busy, step;
  logic [AW-1:0] ptr_base [NPTR];
  logic          ptr_inc  [NPTR];
  logic [AW-1:0] ptr_addr [NPTR];

  dma_cfg #(.AW(AW), .LW(LW), .BW(BW), .CW(CW)) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .busy_i(busy),
    .src_o(src_base), .dst_o(dst_base), .len_o(len), .blk_o(blk),
    .src_inc_o(src_inc), .dst_inc_o(dst_inc), .rpt_o(rpt),
    .start_o(start), .abort_o(abort_req)
  );

  assign ptr_base[0] = src_base;
  assign ptr_base[1] = dst_base;
  assign ptr_inc[0]  = src_inc;
  assign ptr_inc[1]  = dst_inc;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_ptr #(.AW(AW)) i_ptr (
      .clk_i, .rst_ni,
      .load_i(start), .base_i(ptr_base[g]), .step_i(step), .inc_i(ptr_inc[g]),
      .addr_o(ptr_addr[g])
    );
  end

  dma_engine #(.AW(AW), .DW(DW), .LW(LW), .BW(BW)) i_engine (
    .clk_i, .rst_ni,
    .start_i(start), .abort_i(abort_req), .len_i(len), .blk_i(blk), .rpt_i(rpt),
    .trig_i, .src_addr_i(ptr_addr[0]), .dst_addr_i(ptr_addr[1]),
    .bus_ack_i, .bus_rdy_i, .bus_rdata_i,
    .busy_o(busy), .step_o(step),
    .bus_req_o, .bus_stb_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .done_o, .aborted_o, .irq_o
  );

  // R3: memory cycles only while the bus is granted
  p_stb_owned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stb_o |-> (bus_req_o && bus_ack_i));
  // R7: a pending cycle keeps its address, direction and data
  p_hold_until_rdy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_stb_o && !bus_rdy_i) |=> (bus_stb_o && $stable(bus_addr_o)
                                   && $stable(bus_we_o) && $stable(bus_wdata_o)));
endmodule

// File: tb/test_dma_ctrl.sv
module test_dma_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        trig = 1'b0;
  logic        req, ack, stb, we, rdy, done, aborted, irq;
  logic [15:0] addr, wdata, rdata;

  logic [15:0] mem [256];
  logic        req_d;
  int          mem_wait = 0;
  int          wcnt = 0;
  int          wr_count = 0;
  int          req_rises = 0;
  int          irq_count = 0;
  logic        req_prev = 1'b0;
  int          checks = 0;
  int          failures = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_ctrl i_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .trig_i(trig),
    .bus_req_o(req), .bus_ack_i(ack), .bus_stb_o(stb), .bus_we_o(we),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_rdy_i(rdy),
    .done_o(done), .aborted_o(aborted), .irq_o(irq)
  );

  // CPU side: acknowledge follows request with two cycles of latency
  always @(posedge clk) begin
    if (!rst_n) begin
      req_d <= 1'b0; ack <= 1'b0; req_prev <= 1'b0;
    end else begin
      req_d <= req; ack <= req_d; req_prev <= req;
      if (req && !req_prev) req_rises <= req_rises + 1;
      if (irq) irq_count <= irq_count + 1;
    end
  end

  // memory with programmable wait states
  always @(posedge clk) begin
    if (!rst_n) begin
      rdy <= 1'b0; wcnt <= 0; rdata <= '0;
    end else if (rdy) begin
      rdy <= 1'b0; wcnt <= 0;
    end else if (stb) begin
      if (wcnt >= mem_wait) begin
        rdy <= 1'b1;
        if (we) begin
          mem[addr[7:0]] <= wdata;
          wr_count <= wr_count + 1;
        end else begin
          rdata <= mem[addr[7:0]];
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++) mem[8'h10 + i] = 16'h1000 + 16'(i * 7);
    for (int i = 0; i < 64; i++) mem[8'h80 + i] = 16'hDEAD;
  endtask

  task automatic prep(input int len, input int blk);
    fill();
    wr_count = 0; req_rises = 0; irq_count = 0;
    cfg_wr(2'd0, 32'h10);
    cfg_wr(2'd1, 32'h80);
    cfg_wr(2'd2, {8'h0, 8'(blk), 16'(len)});
  endtask

  task automatic wait_end();
    for (int i = 0; i < 4000; i++) begin
      if (done || aborted) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(!req && !stb && !done && !aborted && !irq, "R11 reset outputs",
          {req, stb, done, aborted, irq}, 0);
  endtask

  task automatic t_copy_bursts();
    bit ok = 1;
    mem_wait = 2;
    prep(6, 4);
    cfg_wr(2'd3, 32'h07);
    repeat (12) @(negedge clk);
    check(req_rises == 0, "R2 no request before trigger", req_rises, 0);
    pulse_trig();
    wait_end();
    for (int i = 0; i < 6; i++) if (mem[8'h80 + i] !== mem[8'h10 + i]) ok = 0;
    check(ok, "R5 R7 stepping copy data", mem[8'h85], mem[8'h15]);
    check(mem[8'h86] == 16'hDEAD, "R1 count respected", mem[8'h86], 16'hDEAD);
    check(req_rises == 2, "R4 two ownership periods", req_rises, 2);
    check(done && !aborted, "R8 done flag", {done, aborted}, 2'b10);
    check(irq_count == 1, "R8 one irq pulse", irq_count, 1);
  endtask

  task automatic t_fixed_src();
    mem_wait = 0;
    prep(3, 0);
    cfg_wr(2'd3, 32'h05);
    pulse_trig();
    wait_end();
    check(mem[8'h80] == mem[8'h10] && mem[8'h81] == mem[8'h10] && mem[8'h82] == mem[8'h10],
          "R5 fixed source", mem[8'h82], mem[8'h10]);
    check(req_rises == 1, "R4 burst size zero single period", req_rises, 1);
  endtask

  task automatic t_fixed_dst();
    mem_wait = 1;
    prep(4, 2);
    cfg_wr(2'd3, 32'h03);
    pulse_trig();
    wait_end();
    check(mem[8'h80] == mem[8'h13] && mem[8'h81] == 16'hDEAD, "R5 fixed destination",
          mem[8'h80], mem[8'h13]);
    check(wr_count == 4, "R5 write count", wr_count, 4);
  endtask

  task automatic t_repeat();
    mem_wait = 0;
    prep(6, 3);
    cfg_wr(2'd3, 32'h0F);
    pulse_trig();
    repeat (60) @(negedge clk);
    check(req_rises == 1 && !done && mem[8'h83] == 16'hDEAD && mem[8'h82] == mem[8'h12],
          "R6 waits for next trigger", req_rises, 1);
    pulse_trig();
    wait_end();
    check(done && req_rises == 2 && mem[8'h85] == mem[8'h15], "R6 second burst done",
          req_rises, 2);
  endtask

  task automatic t_zero_len();
    prep(0, 2);
    cfg_wr(2'd3, 32'h07);
    @(negedge clk);
    check(done && req_rises == 0 && irq_count == 1, "R8 zero count done at once",
          {done, 8'(req_rises)}, 9'h100);
  endtask

  task automatic t_ignore_busy();
    bit ok = 1;
    mem_wait = 1;
    prep(8, 2);
    cfg_wr(2'd3, 32'h07);
    pulse_trig();
    repeat (5) @(negedge clk);
    cfg_wr(2'd2, 32'h1);
    cfg_wr(2'd0, 32'h30);
    cfg_wr(2'd3, 32'h01);
    wait_end();
    for (int i = 0; i < 8; i++) if (mem[8'h80 + i] !== mem[8'h10 + i]) ok = 0;
    check(ok && wr_count == 8, "R9 busy writes ignored", wr_count, 8);
    check(req_rises == 4, "R9 R4 burst count unchanged", req_rises, 4);
  endtask

  task automatic t_abort();
    int n;
    mem_wait = 3;
    prep(20, 0);
    cfg_wr(2'd3, 32'h07);
    pulse_trig();
    for (int i = 0; i < 2000 && wr_count < 3; i++) @(negedge clk);
    cfg_wr(2'd3, 32'h10);
    wait_end();
    n = wr_count;
    check(aborted && !done, "R10 aborted flag", {aborted, done}, 2'b10);
    check(n >= 3 && n < 20 && !req, "R10 stopped early bus returned", n, 3);
    check(mem[8'h80 + n - 1] == mem[8'h10 + n - 1] && mem[8'h80 + n] == 16'hDEAD,
          "R10 word in flight completed", mem[8'h80 + n - 1], mem[8'h10 + n - 1]);
    check(irq_count == 1, "R10 irq pulse", irq_count, 1);
    prep(0, 0);
    cfg_wr(2'd3, 32'h01);
    @(negedge clk);
    check(done && !aborted, "R11 start clears status", {done, aborted}, 2'b10);
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_copy_bursts();
    t_fixed_src();
    t_fixed_dst();
    t_repeat();
    t_zero_len();
    t_ignore_busy();
    t_abort();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule